// File: doc/BRIEF.md
# Loop-State Status Bank with Transition Flags

This block holds one read-only status byte for each of several digital PLL channels. Each byte reports two things. The low nibble carries the loop-state code that the channel's loop controller is driving at that moment. Two latched flags record whether the loop has entered or left the locked state, and whether it has entered or left the holdover state, at any point since the flag was last cleared.

Each channel registers its incoming state code on every clock. It compares the new code with the stored one to detect a transition that touches the target state. A flag stays set until that channel's own clear strobe arrives. If a qualifying transition occurs in the same cycle as the clear, the flag stays set.

The host reads the bytes over a simple parallel bus. Channel i sits at byte address BASE_ADDR + i. Read data is registered, with one cycle of latency. A read of any other address returns zero, and a write cycle has no effect.

Top module: `dpll_status_bank`

## Requirements
- R1: After reset, every channel's status byte and the read data output are 0x00.
- R2: Bits [3:0] of a channel's byte show the state code registered from that channel's input on the previous clock. The codes are freerun = 0, lock acquisition = 1, lock recovery = 2, locked = 3, holdover = 4 and open loop = 5. Codes 6 to 15 pass through unchanged.
- R3: Bit 4 sets when the registered code changes from 3 to any other value, or from any other value to 3. Codes above 5 count as neither locked nor holdover.
- R4: Bit 5 sets when the registered code changes from 4 to any other value, or from any other value to 4.
- R5: Once bit 4 or bit 5 is set, it stays set through any later state changes until that channel's clear strobe is sampled high.
- R6: A clear strobe sampled in the same cycle as a qualifying transition leaves the flag set. A clear strobe with no qualifying transition drops the flag to 0 on that edge.
- R7: Bits [7:6] of every byte read back as 0.
- R8: Channel i is mapped at byte address BASE_ADDR + i. The byte appears on the read data output after the clock edge that samples the read strobe high. The read data output holds its value in cycles with no read.
- R9: A read of an address with no channel mapped to it returns 0x00.
- R10: A cycle with the write strobe high changes neither the read data output nor any status byte, even when the read strobe is also high.
- R11: A clear strobe on one channel does not change the flags of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_state_i | input | N_CH*4 | Loop-state code per channel; channel i occupies bits [4i+3:4i] |
| sticky_clr_i | input | N_CH | Per-channel flag clear strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe; the write has no effect |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_rdata_o | output | 8 | Registered read data |

## Verification
The bench builds the block with three channels and a base address of 0x1B, so the mapped bytes sit at 0x1B to 0x1D. The bench also probes the neighbouring unmapped addresses 0x1A and 0x1E. This small size allows a full sweep of all 16×16 old/new code pairs on every channel, including the out-of-range codes. Each pair is run after a clear, so the expected flags follow directly from whether the old or the new code equals 3 or 4. Targeted sequences then cover clear-versus-set collisions, isolation between channels, read latency and ignored write cycles.

// File: rtl/dpll_status_pkg.sv
package dpll_status_pkg;
  localparam int STATE_W = 4;
  localparam int BYTE_W  = 8;

  typedef enum logic [STATE_W-1:0] {
    ST_FREERUN = 4'd0,
    ST_ACQUIRE = 4'd1,
    ST_RECOVER = 4'd2,
    ST_LOCKED  = 4'd3,
    ST_HOLD    = 4'd4,
    ST_OPEN    = 4'd5
  } loop_state_e;

  // True when a step from prev to cur enters or leaves target.
  function automatic logic crosses(input logic [STATE_W-1:0] prev,
                                   input logic [STATE_W-1:0] cur,
                                   input logic [STATE_W-1:0] target);
    return (prev != cur) && ((prev == target) || (cur == target));
  endfunction

  // Status byte layout: {2'b00, hold flag, lock flag, state code}.
  function automatic logic [BYTE_W-1:0] pack_status(input logic hold,
                                                    input logic lock,
                                                    input logic [STATE_W-1:0] st);
    return {2'b00, hold, lock, st};
  endfunction
endpackage

// File: rtl/dpll_stat_chan.sv
module dpll_stat_chan
  import dpll_status_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [STATE_W-1:0]   state_i,
  input  logic                 clr_i,
  output logic [BYTE_W-1:0]    status_o,
  output logic                 lock_ev_o,
  output logic                 hold_ev_o,
  output logic                 lock_o,
  output logic                 hold_o
);
  logic [STATE_W-1:0] state_q;
  logic               lock_q;
  logic               hold_q;

  assign lock_ev_o = crosses(state_q, state_i, ST_LOCKED);
  assign hold_ev_o = crosses(state_q, state_i, ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      lock_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_i;
      // a fresh event outranks the clear
      lock_q  <= lock_ev_o | (lock_q & ~clr_i);
      hold_q  <= hold_ev_o | (hold_q & ~clr_i);
    end
  end

  assign lock_o   = lock_q;
  assign hold_o   = hold_q;
  assign status_o = pack_status(hold_q, lock_q, state_q);
endmodule

// File: rtl/dpll_stat_rd.sv
module dpll_stat_rd
  import dpll_status_pkg::*;
#(
  parameter int                 N_CH      = 4,
  parameter int                 ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 'h1B
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH*BYTE_W-1:0]   status_i,
  input  logic                     rd_i,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [BYTE_W-1:0]        rdata_o,
  output logic                     hit_o
);
  logic [ADDR_W-1:0] offset;
  logic [BYTE_W-1:0] sel;
  logic              load;

  assign offset = addr_i - BASE_ADDR;
  assign load   = rd_i & ~wr_i;

  always_comb begin
    hit_o = 1'b0;
    sel   = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (offset == ADDR_W'(i)) begin
        hit_o = 1'b1;
        sel   = status_i[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (load) rdata_o <= hit_o ? sel : '0;
  end
endmodule

// File: rtl/dpll_status_bank.sv
module dpll_status_bank
  import dpll_status_pkg::*;
#(
  parameter int                 N_CH      = 4,
  parameter int                 ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 'h1B
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CH*STATE_W-1:0]   loop_state_i,
  input  logic [N_CH-1:0]           sticky_clr_i,
  input  logic                      bus_rd_i,
  input  logic                      bus_wr_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  output logic [BYTE_W-1:0]         bus_rdata_o
);
  localparam int STATUS_W = N_CH * BYTE_W;

  logic [STATUS_W-1:0] status_bus;
  logic [N_CH-1:0]     lock_ev;
  logic [N_CH-1:0]     hold_ev;
  logic [N_CH-1:0]     lock_flag;
  logic [N_CH-1:0]     hold_flag;
  logic                addr_hit;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    dpll_stat_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .state_i   (loop_state_i[c*STATE_W +: STATE_W]),
      .clr_i     (sticky_clr_i[c]),
      .status_o  (status_bus[c*BYTE_W +: BYTE_W]),
      .lock_ev_o (lock_ev[c]),
      .hold_ev_o (hold_ev[c]),
      .lock_o    (lock_flag[c]),
      .hold_o    (hold_flag[c])
    );
  end

  dpll_stat_rd #(
    .N_CH      (N_CH),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_bus),
    .rd_i     (bus_rd_i),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .rdata_o  (bus_rdata_o),
    .hit_o    (addr_hit)
  );
endmodule

// File: rtl/dpll_status_bank_chk.sv
module dpll_status_bank_chk #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] sticky_clr_i,
  input logic            bus_rd_i,
  input logic            bus_wr_i,
  input logic [7:0]      bus_rdata_o,
  input logic [N_CH-1:0] lock_ev,
  input logic [N_CH-1:0] hold_ev,
  input logic [N_CH-1:0] lock_flag,
  input logic [N_CH-1:0] hold_flag,
  input logic            addr_hit
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    a_r3_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
      lock_ev[c] |=> lock_flag[c]);
    a_r4_hold_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ev[c] |=> hold_flag[c]);
    a_r5_lock_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_flag[c] && !sticky_clr_i[c]) |=> lock_flag[c]);
    a_r5_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_flag[c] && !sticky_clr_i[c]) |=> hold_flag[c]);
    a_r6_lock_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_clr_i[c] && !lock_ev[c]) |=> !lock_flag[c]);
    a_r6_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_clr_i[c] && !hold_ev[c]) |=> !hold_flag[c]);
    a_r3_no_spurious_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_flag[c] && !lock_ev[c]) |=> !lock_flag[c]);
  end

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_o[7:6] == 2'b00);
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && !bus_wr_i && !addr_hit) |=> (bus_rdata_o == 8'h00));
  a_r10_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_i |=> $stable(bus_rdata_o));
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

bind dpll_status_bank dpll_status_bank_chk #(.N_CH(N_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sticky_clr_i (sticky_clr_i),
  .bus_rd_i     (bus_rd_i),
  .bus_wr_i     (bus_wr_i),
  .bus_rdata_o  (bus_rdata_o),
  .lock_ev      (lock_ev),
  .hold_ev      (hold_ev),
  .lock_flag    (lock_flag),
  .hold_flag    (hold_flag),
  .addr_hit     (addr_hit)
);

// File: tb/dpll_status_bank_tb.sv
module dpll_status_bank_tb;
  localparam int         NCH  = 3;
  localparam int         AW   = 8;
  localparam logic [7:0] BASE = 8'h1B;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH*4-1:0] st = '0;
  logic [NCH-1:0]  clr = '0;
  logic            rd = 1'b0;
  logic            wr = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [7:0]      rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dpll_status_bank #(.N_CH(NCH), .ADDR_W(AW), .BASE_ADDR(BASE)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .loop_state_i (st),
    .sticky_clr_i (clr),
    .bus_rd_i     (rd),
    .bus_wr_i     (wr),
    .bus_addr_i   (addr),
    .bus_rdata_o  (rdata)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic set_state(input int ch, input logic [3:0] v);
    st[ch*4 +: 4] = v;
  endtask

  task automatic read_byte(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    rd   = 1'b1;
    tick();
    rd   = 1'b0;
    d    = rdata;
  endtask

  // Expected byte built from the requirement text: a flag is set when exactly
  // one of the two codes is the target code.
  function automatic logic [7:0] expect_pair(input logic [3:0] a, input logic [3:0] b);
    logic lk, hd;
    lk = (a == 4'd3) ^ (b == 4'd3);
    hd = (a == 4'd4) ^ (b == 4'd4);
    return {2'b00, hd, lk, b};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] keep;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    check("R1 rdata after reset", rdata, 8'h00);
    for (int c = 0; c < NCH; c++) begin
      read_byte(BASE + 8'(c), d);
      check("R1 channel byte after reset", d, 8'h00);
    end

    // R2 R3 R4 R7 R8: full sweep of code pairs on every channel
    for (int c = 0; c < NCH; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          set_state(c, 4'(a));
          tick();
          tick();
          clr[c] = 1'b1;
          tick();
          clr[c] = 1'b0;
          set_state(c, 4'(b));
          tick();
          read_byte(BASE + 8'(c), d);
          check("R2/R3/R4/R7 sweep pair", d, expect_pair(4'(a), 4'(b)));
        end
      end
      set_state(c, 4'd0);
      tick();
      clr[c] = 1'b1;
      tick();
      clr[c] = 1'b0;
    end

    // R9 unmapped addresses
    read_byte(8'h1A, d);  check("R9 below base", d, 8'h00);
    read_byte(8'h1E, d);  check("R9 above last", d, 8'h00);
    read_byte(8'h00, d);  check("R9 address 0", d, 8'h00);
    read_byte(8'hFF, d);  check("R9 address ff", d, 8'h00);

    // R5 flag persists through later non-target changes; code above 5 passes
    set_state(2, 4'd3); tick();
    set_state(2, 4'd1); tick();
    set_state(2, 4'd2); tick();
    set_state(2, 4'd6); tick(); tick();
    read_byte(BASE + 8'd2, d);
    check("R5 lock flag persists", d, 8'h16);

    // R8 latency: rdata still old before the edge, new after it
    read_byte(8'h1E, d);
    addr = BASE + 8'd2;
    rd = 1'b1;
    #1;
    check("R8 no change before edge", rdata, 8'h00);
    tick();
    rd = 1'b0;
    check("R8 byte after one edge", rdata, 8'h16);
    tick(); tick();
    check("R8 holds while idle", rdata, 8'h16);

    // R10 writes ignored
    keep = rdata;
    addr = BASE + 8'd2; rd = 1'b1; wr = 1'b1;
    tick();
    rd = 1'b0;
    check("R10 read+write cycle leaves rdata", rdata, keep);
    addr = BASE; tick();
    wr = 1'b0;
    check("R10 write cycle leaves rdata", rdata, keep);
    read_byte(BASE + 8'd2, d);
    check("R10 status unchanged after writes", d, 8'h16);

    // R6 set wins over a same-cycle clear
    set_state(1, 4'd0); tick();
    clr[1] = 1'b1; tick();
    set_state(1, 4'd4); tick();
    clr[1] = 1'b0; tick();
    read_byte(BASE + 8'd1, d);
    check("R6 set wins over clear", d, 8'h24);
    clr[1] = 1'b1; tick();
    clr[1] = 1'b0;
    read_byte(BASE + 8'd1, d);
    check("R6 plain clear drops flags", d, 8'h04);

    // R11 clear isolation
    set_state(0, 4'd3); set_state(1, 4'd3); tick();
    clr[0] = 1'b1; tick();
    clr[0] = 1'b0;
    read_byte(BASE, d);
    check("R11 cleared channel", d, 8'h03);
    read_byte(BASE + 8'd1, d);
    check("R11 neighbour keeps lock flag", d, 8'h33);
    read_byte(BASE + 8'd2, d);
    check("R11 far channel untouched", d, 8'h16);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule